// File: doc/BRIEF.md
# Segment Column Data Capture with Cascaded Enable

This block takes in one display line of column data for a dot-matrix segment driver. A controller puts pixel groups on a parallel bus and toggles a data shift clock. The block samples a group on each falling edge of that clock and writes it into a data latch that is one bit wide per column. A bus-width select picks 4-bit groups or 8-bit groups. A direction select decides whether the line fills from the first column upward or from the last column downward. Capture starts only while the chip's enable input is low. The block counts the groups by itself. After the last group it ignores the shift clock and pulls its enable output low for one shift-clock period, so that the next chip in a cascade takes over the bus.

A falling edge on the line pulse copies the whole data latch into the line latch and re-arms the counter for the next line. Each column output is a 2-bit level code. The code comes from the column's line-latch bit and the frame-inversion input. A low display-off input clears the line latch and holds every column at the deselect level. The data latch keeps capturing during display-off. The design runs on a fast system clock, and the shift clock and line pulse are sampled as ordinary inputs.

Top module: `seg_capture`

## Requirements
- R1: After reset, every line-latch bit is 0. Both enable outputs are high, and every column code is the code for a 0 bit under the present frame-inversion value.
- R2: With `nib_mode`=1, each group is `seg_dat[3:0]` and `seg_dat[7:4]` is ignored. A line is 60 groups for 240 columns.
- R3: With `nib_mode`=0, each group is `seg_dat[7:0]`. A line is 30 groups.
- R4: A group is sampled only on a falling edge of `shift_clk`. The bus value at the rising edge has no effect.
- R5: Take bus bit i of group g and let p = g*W+i, where W is the group width. With `dir_fwd`=1 the bit goes to column p. With `dir_fwd`=0 it goes to column 239-p. Column c drives `col_lvl[2c+1:2c]`.
- R6: Capture of a line starts only at a shift-clock fall while the entry enable input is low. The entry input is `en_a_in` when `dir_fwd`=1 and `en_b_in` when `dir_fwd`=0. Falls seen while the chip is not selected leave the data latch unchanged.
- R7: When the last group of a line is captured, the exit enable output goes low. The exit output is `en_b_out` for a forward fill and `en_a_out` for a reverse fill. It goes back high at the next shift-clock fall. From then until the next line-pulse fall, all shift-clock falls are ignored. The two enable outputs are never low at the same time.
- R8: A falling edge of `line_pulse` copies the data latch into the line latch and re-arms capture. A line pulse that arrives mid-line ends that line. The line latch changes only on a line-pulse fall or during display-off.
- R9: Column codes are 00=V0, 01=V12, 10=V43 and 11=V5. A line bit of 1 gives 00 when `frame_inv`=1 and 11 when it is 0. A line bit of 0 gives 01 when `frame_inv`=1 and 10 when it is 0.
- R10: While `disp_off_n`=0, every column code is 11 and the line latch is cleared, including on a line-pulse fall. Capture into the data latch goes on. After release, the columns show a cleared line until the next line-pulse fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seg_dat | input | 8 | Pixel group bus |
| nib_mode | input | 1 | 1: 4-bit groups, 0: 8-bit groups |
| dir_fwd | input | 1 | 1: fill from column 0 upward, 0: from the last column down |
| shift_clk | input | 1 | Data shift clock; groups are taken on its falling edge |
| line_pulse | input | 1 | Line pulse; its falling edge transfers the line and re-arms capture |
| en_a_in | input | 1 | Active-low enable in, used as the entry for a forward fill |
| en_b_in | input | 1 | Active-low enable in, used as the entry for a reverse fill |
| en_a_out | output | 1 | Active-low enable out, the exit for a reverse fill |
| en_b_out | output | 1 | Active-low enable out, the exit for a forward fill |
| disp_off_n | input | 1 | Display off, active low |
| frame_inv | input | 1 | Frame inversion select for the level coding |
| col_lvl | output | 480 | Two-bit level code per column |

## Verification
The bench runs full lines in every combination of bus width, fill direction and frame polarity. It puts a different value on the bus at each rising edge than at the falling edge, which exposes a design that samples on the wrong edge. Upper-nibble data in 4-bit mode catches a latch that takes the wrong bits or reverses column order. Extra shift-clock falls after the last group, and a line sent while deselected or with enable on the wrong pin, would overwrite columns in a design that does not stop or does not route enable by direction. A line pulse mid-line, and a line pulse plus new data sent during display-off, show whether re-arming is wrong, whether capture wrongly halts, or whether the line latch leaks data through display-off.

// File: rtl/seg_capture_pkg.sv
package seg_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_HANDOFF = 2'd2,
    ST_DONE    = 2'd3
  } fill_st_e;

  localparam logic [1:0] LV_V0  = 2'b00;
  localparam logic [1:0] LV_V12 = 2'b01;
  localparam logic [1:0] LV_V43 = 2'b10;
  localparam logic [1:0] LV_V5  = 2'b11;

endpackage

// File: rtl/seg_fall_det.sv
module seg_fall_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = sig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign fall = prev_q & ~sig;

endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
  import seg_capture_pkg::*;
#(
  parameter int N_COL = 240,
  parameter int BUS_W = 8,
  localparam int NARROW = BUS_W / 2,
  localparam int GRP_N  = N_COL / NARROW,
  localparam int GRP_W  = N_COL / BUS_W,
  localparam int GW     = $clog2(GRP_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xck_fall,
  input  logic          lp_fall,
  input  logic          nib_mode,
  input  logic          dir_fwd,
  input  logic          en_a_in,
  input  logic          en_b_in,
  output logic          en_a_out,
  output logic          en_b_out,
  output logic          cap_en,
  output logic          cap_nib,
  output logic          cap_fwd,
  output logic [GW-1:0] grp
);

  fill_st_e      state_q, state_d;
  logic [GW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic          dir_q, dir_d;
  logic          sel_n;
  logic [GW-1:0] last_idx;

  assign sel_n    = dir_fwd ? en_a_in : en_b_in;
  assign last_idx = mode_q ? GW'(GRP_N - 1) : GW'(GRP_W - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    dir_d   = dir_q;
    cap_en  = 1'b0;
    if (lp_fall) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (xck_fall) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!sel_n) begin
            cap_en  = 1'b1;
            mode_d  = nib_mode;
            dir_d   = dir_fwd;
            cnt_d   = GW'(1);
            state_d = ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          cap_en = 1'b1;
          if (cnt_q == last_idx) begin
            cnt_d   = '0;
            state_d = ST_HANDOFF;
          end else begin
            cnt_d = cnt_q + GW'(1);
          end
        end
        ST_HANDOFF: state_d = ST_DONE;
        default:    state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      dir_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      dir_q   <= dir_d;
    end
  end

  assign grp      = cnt_q;
  assign cap_nib  = (state_q == ST_IDLE) ? nib_mode : mode_q;
  assign cap_fwd  = (state_q == ST_IDLE) ? dir_fwd  : dir_q;
  assign en_b_out = !((state_q == ST_HANDOFF) &&  dir_q);
  assign en_a_out = !((state_q == ST_HANDOFF) && !dir_q);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE) |-> (cnt_q != '0 && cnt_q <= last_idx)); // R2
  AST_ONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!en_a_out && !en_b_out)); // R7
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !lp_fall) |=> (state_q == ST_DONE)); // R7
  AST_HANDOFF_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HANDOFF && xck_fall && !lp_fall) |=> (en_a_out && en_b_out)); // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> (state_q == ST_IDLE && cnt_q == '0)); // R8

endmodule

// File: rtl/seg_data_latch.sv
module seg_data_latch #(
  parameter int N_COL = 240,
  parameter int BUS_W = 8,
  localparam int NARROW = BUS_W / 2,
  localparam int GRP_N  = N_COL / NARROW,
  localparam int GW     = $clog2(GRP_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_nib,
  input  logic             cap_fwd,
  input  logic [GW-1:0]    grp,
  input  logic [BUS_W-1:0] seg_dat,
  output logic [N_COL-1:0] data_q
);

  logic [N_COL-1:0] data_d;

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    localparam int PF  = c;
    localparam int PR  = N_COL - 1 - c;
    localparam int GNF = PF / NARROW;
    localparam int BNF = PF % NARROW;
    localparam int GWF = PF / BUS_W;
    localparam int BWF = PF % BUS_W;
    localparam int GNR = PR / NARROW;
    localparam int BNR = PR % NARROW;
    localparam int GWR = PR / BUS_W;
    localparam int BWR = PR % BUS_W;
    logic hit;
    logic val;

    always_comb begin
      unique case ({cap_nib, cap_fwd})
        2'b11: begin hit = (grp == GW'(GNF)); val = seg_dat[BNF]; end
        2'b10: begin hit = (grp == GW'(GNR)); val = seg_dat[BNR]; end
        2'b01: begin hit = (grp == GW'(GWF)); val = seg_dat[BWF]; end
        default: begin hit = (grp == GW'(GWR)); val = seg_dat[BWR]; end
      endcase
      data_d[c] = (cap_en && hit) ? val : data_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  AST_HOLD_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(data_q)); // R6

endmodule

// File: rtl/seg_line_drv.sv
module seg_line_drv
  import seg_capture_pkg::*;
#(
  parameter int N_COL = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lp_fall,
  input  logic               disp_off_n,
  input  logic               frame_inv,
  input  logic [N_COL-1:0]   data_q,
  output logic [2*N_COL-1:0] col_lvl
);

  logic [N_COL-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (!disp_off_n)  line_d = '0;
    else if (lp_fall) line_d = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  for (genvar c = 0; c < N_COL; c++) begin : g_lvl
    always_comb begin
      if (!disp_off_n)    col_lvl[2*c +: 2] = LV_V5;
      else if (line_q[c]) col_lvl[2*c +: 2] = frame_inv ? LV_V0  : LV_V5;
      else                col_lvl[2*c +: 2] = frame_inv ? LV_V12 : LV_V43;
    end
  end

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |=> (line_q == '0)); // R10
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && !lp_fall) |=> $stable(line_q)); // R8

endmodule

// File: rtl/seg_capture.sv
module seg_capture #(
  parameter int N_COL = 240,
  parameter int BUS_W = 8,
  localparam int NARROW = BUS_W / 2,
  localparam int GRP_N  = N_COL / NARROW,
  localparam int GW     = $clog2(GRP_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_W-1:0]   seg_dat,
  input  logic               nib_mode,
  input  logic               dir_fwd,
  input  logic               shift_clk,
  input  logic               line_pulse,
  input  logic               en_a_in,
  input  logic               en_b_in,
  output logic               en_a_out,
  output logic               en_b_out,
  input  logic               disp_off_n,
  input  logic               frame_inv,
  output logic [2*N_COL-1:0] col_lvl
);

  logic [1:0]       falls;
  logic             xck_fall, lp_fall;
  logic             cap_en, cap_nib, cap_fwd;
  logic [GW-1:0]    grp;
  logic [N_COL-1:0] data_q;

  seg_fall_det #(.W(2)) u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({line_pulse, shift_clk}),
    .fall (falls)
  );

  assign xck_fall = falls[0];
  assign lp_fall  = falls[1];

  seg_fill_ctrl #(.N_COL(N_COL), .BUS_W(BUS_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .xck_fall(xck_fall),
    .lp_fall (lp_fall),
    .nib_mode(nib_mode),
    .dir_fwd (dir_fwd),
    .en_a_in (en_a_in),
    .en_b_in (en_b_in),
    .en_a_out(en_a_out),
    .en_b_out(en_b_out),
    .cap_en  (cap_en),
    .cap_nib (cap_nib),
    .cap_fwd (cap_fwd),
    .grp     (grp)
  );

  seg_data_latch #(.N_COL(N_COL), .BUS_W(BUS_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .cap_nib(cap_nib),
    .cap_fwd(cap_fwd),
    .grp    (grp),
    .seg_dat(seg_dat),
    .data_q (data_q)
  );

  seg_line_drv #(.N_COL(N_COL)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_fall   (lp_fall),
    .disp_off_n(disp_off_n),
    .frame_inv (frame_inv),
    .data_q    (data_q),
    .col_lvl   (col_lvl)
  );

endmodule

// File: tb/seg_capture_tb_top.sv
module seg_capture_tb_top;

  localparam int N = 240;
  localparam int GN = N / 4;
  localparam int GB = N / 8;

  // mode, dir, fr, seed
  localparam logic [10:0] VEC [0:5] = '{
    {1'b1, 1'b1, 1'b1, 8'h11},
    {1'b1, 1'b0, 1'b0, 8'h2C},
    {1'b0, 1'b1, 1'b0, 8'h47},
    {1'b0, 1'b0, 1'b1, 8'h93},
    {1'b1, 1'b0, 1'b1, 8'hE5},
    {1'b0, 1'b1, 1'b1, 8'h3A}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     seg_dat;
  logic           nib_mode, dir_fwd, shift_clk, line_pulse;
  logic           en_a_in, en_b_in, en_a_out, en_b_out;
  logic           disp_off_n, frame_inv;
  logic [2*N-1:0] col_lvl;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [N-1:0] exp_line;

  always #5 clk = ~clk;

  seg_capture dut_i (
    .clk(clk), .rst_n(rst_n), .seg_dat(seg_dat), .nib_mode(nib_mode),
    .dir_fwd(dir_fwd), .shift_clk(shift_clk), .line_pulse(line_pulse),
    .en_a_in(en_a_in), .en_b_in(en_b_in), .en_a_out(en_a_out),
    .en_b_out(en_b_out), .disp_off_n(disp_off_n), .frame_inv(frame_inv),
    .col_lvl(col_lvl)
  );

  function automatic logic [7:0] gv(int s, int g);
    return 8'((s * 37 + g * 13 + ((g * s) >> 2)) ^ (g * 91));
  endfunction

  function automatic logic [2*N-1:0] lvl_of(logic [N-1:0] ln, logic off, logic fr);
    logic [2*N-1:0] r;
    for (int c = 0; c < N; c++) begin
      if (off)        r[2*c +: 2] = 2'b11;
      else if (ln[c]) r[2*c +: 2] = fr ? 2'b00 : 2'b11;
      else            r[2*c +: 2] = fr ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  task automatic load_exp(logic m, logic d, int s, int g);
    int w;
    logic [7:0] v;
    w = m ? 4 : 8;
    v = gv(s, g);
    for (int i = 0; i < w; i++) begin
      int pos;
      pos = g * w + i;
      if (d) exp_line[pos] = v[i];
      else   exp_line[N-1-pos] = v[i];
    end
  endtask

  task automatic xck_pulse(logic [7:0] d);
    @(negedge clk);
    seg_dat = ~d;
    shift_clk = 1'b1;
    repeat (2) @(negedge clk);
    seg_dat = d;
    @(negedge clk);
    shift_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic lp_pulse();
    @(negedge clk);
    line_pulse = 1'b1;
    repeat (2) @(negedge clk);
    line_pulse = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_groups(logic m, logic d, int s, int ng);
    for (int g = 0; g < ng; g++) begin
      xck_pulse(gv(s, g));
      load_exp(m, d, s, g);
    end
  endtask

  task automatic check_lvl(string tag, logic off);
    logic [2*N-1:0] e;
    e = lvl_of(exp_line, off, frame_inv);
    checks++;
    if (col_lvl !== e) begin
      errors++;
      $display("FAIL %s col_lvl actual=%h expected=%h", tag, col_lvl, e);
    end
  endtask

  task automatic check_en(string tag, logic ea, logic eb);
    checks++;
    if (en_a_out !== ea || en_b_out !== eb) begin
      errors++;
      $display("FAIL %s en_a_out/en_b_out actual=%b%b expected=%b%b",
               tag, en_a_out, en_b_out, ea, eb);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; seg_dat = '0; nib_mode = 1'b1; dir_fwd = 1'b1;
    shift_clk = 1'b0; line_pulse = 1'b0; en_a_in = 1'b1; en_b_in = 1'b1;
    disp_off_n = 1'b1; frame_inv = 1'b1;
    exp_line = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check_lvl("R1 reset columns", 1'b0);
    check_en("R1 reset enables", 1'b1, 1'b1);

    // Table walk: R2 R3 R5 R7 R8 R9
    for (int v = 0; v < 6; v++) begin
      logic m, d, f;
      int s, ng;
      {m, d, f} = VEC[v][10:8];
      s = int'(VEC[v][7:0]);
      ng = m ? GN : GB;
      nib_mode = m; dir_fwd = d; frame_inv = f;
      if (d) en_a_in = 1'b0; else en_b_in = 1'b0;
      send_groups(m, d, s, ng);
      check_en("R7 exit pulse after last group", d, !d);
      en_a_in = 1'b1; en_b_in = 1'b1;
      xck_pulse(8'hA5);
      check_en("R7 exit ends at next fall", 1'b1, 1'b1);
      xck_pulse(8'hFF);
      xck_pulse(8'h00);
      lp_pulse();
      check_lvl("R2/R3/R4/R5/R8/R9 line contents", 1'b0);
    end

    // R9: frame inversion flip without a new line
    frame_inv = ~frame_inv;
    @(negedge clk);
    check_lvl("R9 frame flip", 1'b0);

    // R6: deselected and wrong-pin enable leave data latch unchanged
    nib_mode = 1'b0; dir_fwd = 1'b1;
    for (int k = 0; k < 5; k++) xck_pulse(8'hFF);
    lp_pulse();
    check_lvl("R6 deselected falls ignored", 1'b0);
    en_b_in = 1'b0;
    for (int k = 0; k < 5; k++) xck_pulse(8'h5A);
    en_b_in = 1'b1;
    lp_pulse();
    check_lvl("R6 wrong entry pin ignored", 1'b0);

    // R8: line pulse mid-line transfers partial data and re-arms
    nib_mode = 1'b1; dir_fwd = 1'b0; en_b_in = 1'b0;
    send_groups(1'b1, 1'b0, 77, 10);
    lp_pulse();
    check_lvl("R8 partial line after mid-line pulse", 1'b0);
    send_groups(1'b1, 1'b0, 201, GN);
    check_en("R8 rearmed line completes", 1'b0, 1'b1);
    en_b_in = 1'b1;
    xck_pulse(8'h00);
    lp_pulse();
    check_lvl("R8 full line after re-arm", 1'b0);

    // R10: display off
    disp_off_n = 1'b0;
    repeat (2) @(negedge clk);
    check_lvl("R10 outputs deselect", 1'b1);
    nib_mode = 1'b0; dir_fwd = 1'b1; en_a_in = 1'b0;
    send_groups(1'b0, 1'b1, 150, GB);
    en_a_in = 1'b1;
    xck_pulse(8'h00);
    lp_pulse();
    check_lvl("R10 line pulse during off", 1'b1);
    disp_off_n = 1'b1;
    repeat (2) @(negedge clk);
    begin
      logic [N-1:0] keep;
      keep = exp_line;
      exp_line = '0;
      check_lvl("R10 cleared line after release", 1'b0);
      exp_line = keep;
    end
    lp_pulse();
    check_lvl("R10 capture continued during off", 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule